// File: doc/BRIEF.md
# Calendar Counter with Alarm Compare

This block keeps wall-clock time: seconds, minutes, hours, day of week, day of month, month and a two-digit year. A one-cycle pulse on `sec_tick` advances it by one second. The oscillator-control field must hold the run code for the tick to count. Time is held internally in binary. After each accepted tick there is a fixed delay of `UPDATE_DELAY` clock cycles. At the end of that delay the new time is encoded into the visible byte registers, in BCD or binary and in 12-hour or 24-hour form as the mode inputs select.

The update sequence has three steps. The update-in-progress output rises first. When the delay ends, the visible registers are refreshed, the three alarm bytes are compared with the new time, and one-cycle flag pulses report the update, any alarm and the combined interrupt request. A host can write any time field through a simple write port. While the freeze input is low, the write also loads the internal counter at once. While the freeze input is high, writes reach only the visible bytes. Those bytes are loaded into the counter when the freeze is released.

Top module: `cal_counter`

## Requirements
- R1: After reset the visible bytes read seconds 00, minutes 00, hours 00, day of week 01, day of month 01, month 01 and year 00, and `uip`, `upd_flag`, `irq_flag` and `alm_flag` are all low.
- R2: A tick counts only when `osc_ctl` equals 3'b010. With any other code the tick is ignored: `uip` does not rise, no flag pulses and the time bytes are unchanged.
- R3: Fields roll over in this order. Seconds run 0–59, minutes 0–59 and hours 0–23. Day of week runs 1–7 and then wraps to 1. Day of month runs up to the month length. Month runs 1–12, and the year code runs 0–99 and then wraps to 0.
- R4: Month lengths are 31,28,31,30,31,30,31,31,30,31,30,31. February has 29 days when the full year (`BASE_YEAR` plus the year code) is divisible by 4 and is either not divisible by 100 or divisible by 400.
- R5: With `bin_mode`=0 every byte is packed BCD, with the tens digit in bits 7:4 and the units digit in bits 3:0. With `bin_mode`=1 every byte is a plain binary value.
- R6: With `h24_mode`=0 the hours byte holds the hour modulo 12 in bits 6:0 and sets bit 7 for hours 12–23. A written hours byte with bit 7 set is taken as the hour plus 12.
- R7: When `set_mode` is low, an accepted tick raises `uip` in the following cycle, and `uip` stays high for `UPDATE_DELAY` cycles. In the cycle `uip` falls, the new time is visible and `upd_flag` pulses for one cycle.
- R8: `upd_flag` pulses at the end of every update. `irq_flag` pulses with it when `upd_ie`=1 or when the alarm fires.
- R9: An alarm byte whose bits 7:6 are 2'b11 matches any value. Any other alarm byte must equal the new field value, decoded in the current encoding, with the hours alarm taken as 0–23. If all three alarm bytes match and `alm_ie`=1, `alm_flag` and `irq_flag` both pulse.
- R10: While `set_mode` is high, `uip` stays low and the visible time bytes are not refreshed, but `upd_flag` still pulses. When `set_mode` falls, the internal counter is loaded from the visible bytes.
- R11: Field codes for `wr_sel` are 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 day of month, 5 month and 6 year. A write stores `wr_data` in the selected visible byte. When `set_mode` is low, the write also loads the internal field, and the next update continues from that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| osc_ctl | input | 3 | Oscillator control; 3'b010 lets time run |
| set_mode | input | 1 | Freeze visible registers and suppress update-in-progress |
| bin_mode | input | 1 | 1 = binary bytes, 0 = BCD |
| h24_mode | input | 1 | 1 = 24-hour, 0 = 12-hour with PM bit |
| upd_ie | input | 1 | Update interrupt enable |
| alm_ie | input | 1 | Alarm interrupt enable |
| alm_sec | input | 8 | Seconds alarm byte |
| alm_min | input | 8 | Minutes alarm byte |
| alm_hour | input | 8 | Hours alarm byte |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 3 | Field being written (R11 codes) |
| wr_data | input | 8 | Write byte in the current encoding |
| sec_q | output | 8 | Visible seconds |
| min_q | output | 8 | Visible minutes |
| hour_q | output | 8 | Visible hours |
| wday_q | output | 8 | Visible day of week |
| mday_q | output | 8 | Visible day of month |
| mon_q | output | 8 | Visible month |
| year_q | output | 8 | Visible year code |
| uip | output | 1 | Update in progress |
| upd_flag | output | 1 | Update-ended pulse |
| irq_flag | output | 1 | Interrupt-request pulse |
| alm_flag | output | 1 | Alarm pulse |

## Verification
The assertions assume that ticks are spaced more than `UPDATE_DELAY` cycles apart. They also assume that a host write never lands on the same edge as a tick or a release of `set_mode`. Under those conditions each update runs to completion before the next one starts. The bench keeps to these rules in every scenario: each tick task waits for the update to end before it returns, and writes and mode changes are issued only between updates. Written bytes are always legal values in the encoding selected at that moment.

// File: rtl/cal_counter.sv
module cal_counter #(
  parameter int UPDATE_DELAY = 8,
  parameter int BASE_YEAR    = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sec_tick,
  input  logic [2:0] osc_ctl,
  input  logic       set_mode,
  input  logic       bin_mode,
  input  logic       h24_mode,
  input  logic       upd_ie,
  input  logic       alm_ie,
  input  logic [7:0] alm_sec,
  input  logic [7:0] alm_min,
  input  logic [7:0] alm_hour,
  input  logic       wr_en,
  input  logic [2:0] wr_sel,
  input  logic [7:0] wr_data,
  output logic [7:0] sec_q,
  output logic [7:0] min_q,
  output logic [7:0] hour_q,
  output logic [7:0] wday_q,
  output logic [7:0] mday_q,
  output logic [7:0] mon_q,
  output logic [7:0] year_q,
  output logic       uip,
  output logic       upd_flag,
  output logic       irq_flag,
  output logic       alm_flag
);
  localparam int DW = $clog2(UPDATE_DELAY + 1);

  function automatic logic [7:0] enc(input logic [6:0] v, input logic b);
    logic [6:0] t;
    t = v / 7'd10;
    enc = b ? {1'b0, v} : {t[3:0], 4'(v - t * 7'd10)};
  endfunction

  function automatic logic [6:0] dec(input logic [7:0] d, input logic b);
    dec = b ? d[6:0] : 7'({3'b0, d[7:4]} * 7'd10 + {3'b0, d[3:0]});
  endfunction

  function automatic logic [6:0] dec_hr(input logic [7:0] d, input logic b, input logic h24);
    dec_hr = dec({1'b0, d[6:0]}, b) + ((!h24 && d[7]) ? 7'd12 : 7'd0);
  endfunction

  function automatic logic [6:0] month_len(input logic [6:0] m, input logic [6:0] y);
    int full;
    logic leap;
    full = BASE_YEAR + int'(y);
    leap = (full % 4 == 0) && ((full % 100 != 0) || (full % 400 == 0));
    case (m)
      7'd2: month_len = leap ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11: month_len = 7'd30;
      default: month_len = 7'd31;
    endcase
  endfunction

  logic [6:0] s_sec, s_min, s_hr, s_wd, s_md, s_mo, s_yr;
  logic [6:0] n_sec, n_min, n_hr, n_wd, n_md, n_mo, n_yr;
  logic [7:0] vis [7];
  logic [7:0] shown [7];
  logic [DW-1:0] dly;
  logic set_q, alarm_hit;
  wire tick_run = sec_tick && (osc_ctl == 3'b010);
  wire done     = (dly == DW'(1));

  always_comb begin
    {n_sec, n_min, n_hr, n_wd, n_md, n_mo, n_yr} = {s_sec, s_min, s_hr, s_wd, s_md, s_mo, s_yr};
    n_sec = s_sec + 7'd1;
    if (s_sec >= 7'd59) begin
      n_sec = 7'd0;
      n_min = s_min + 7'd1;
      if (s_min >= 7'd59) begin
        n_min = 7'd0;
        n_hr  = s_hr + 7'd1;
        if (s_hr >= 7'd23) begin
          n_hr = 7'd0;
          n_wd = (s_wd >= 7'd7) ? 7'd1 : s_wd + 7'd1;
          n_md = s_md + 7'd1;
          if (s_md >= month_len(s_mo, s_yr)) begin
            n_md = 7'd1;
            n_mo = s_mo + 7'd1;
            if (s_mo >= 7'd12) begin
              n_mo = 7'd1;
              n_yr = (s_yr >= 7'd99) ? 7'd0 : s_yr + 7'd1;
            end
          end
        end
      end
    end
  end

  always_comb begin
    shown[0] = enc(s_sec, bin_mode);
    shown[1] = enc(s_min, bin_mode);
    shown[2] = h24_mode ? enc(s_hr, bin_mode)
             : (enc((s_hr >= 7'd12) ? s_hr - 7'd12 : s_hr, bin_mode) | ((s_hr >= 7'd12) ? 8'h80 : 8'h00));
    shown[3] = enc(s_wd, bin_mode);
    shown[4] = enc(s_md, bin_mode);
    shown[5] = enc(s_mo, bin_mode);
    shown[6] = enc(s_yr, bin_mode);
  end

  assign alarm_hit = (alm_sec[7:6]  == 2'b11 || dec(alm_sec, bin_mode)  == s_sec) &&
                     (alm_min[7:6]  == 2'b11 || dec(alm_min, bin_mode)  == s_min) &&
                     (alm_hour[7:6] == 2'b11 || dec(alm_hour, bin_mode) == s_hr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {s_sec, s_min, s_hr} <= '0;
      s_wd <= 7'd1; s_md <= 7'd1; s_mo <= 7'd1; s_yr <= 7'd0;
      vis[0] <= 8'h00; vis[1] <= 8'h00; vis[2] <= 8'h00; vis[3] <= 8'h01;
      vis[4] <= 8'h01; vis[5] <= 8'h01; vis[6] <= 8'h00;
      dly <= '0; set_q <= 1'b0; uip <= 1'b0;
      upd_flag <= 1'b0; irq_flag <= 1'b0; alm_flag <= 1'b0;
    end else begin
      set_q <= set_mode;
      upd_flag <= 1'b0; irq_flag <= 1'b0; alm_flag <= 1'b0;
      if (tick_run) begin
        dly <= DW'(UPDATE_DELAY);
        if (!set_mode) uip <= 1'b1;
      end else if (dly != '0) begin
        dly <= dly - DW'(1);
        if (done) begin
          uip <= 1'b0;
          upd_flag <= 1'b1;
          irq_flag <= upd_ie || (alm_ie && alarm_hit);
          alm_flag <= alm_ie && alarm_hit;
          if (!set_mode) for (int i = 0; i < 7; i++) vis[i] <= shown[i];
        end
      end
      if (wr_en && wr_sel != 3'd7) begin
        vis[wr_sel] <= wr_data;
        if (!set_mode) begin
          case (wr_sel)
            3'd0: s_sec <= dec(wr_data, bin_mode);
            3'd1: s_min <= dec(wr_data, bin_mode);
            3'd2: s_hr  <= dec_hr(wr_data, bin_mode, h24_mode);
            3'd3: s_wd  <= dec(wr_data, bin_mode);
            3'd4: s_md  <= dec(wr_data, bin_mode);
            3'd5: s_mo  <= dec(wr_data, bin_mode);
            default: s_yr <= dec(wr_data, bin_mode);
          endcase
        end
      end else if (set_q && !set_mode) begin
        s_sec <= dec(vis[0], bin_mode);
        s_min <= dec(vis[1], bin_mode);
        s_hr  <= dec_hr(vis[2], bin_mode, h24_mode);
        s_wd  <= dec(vis[3], bin_mode);
        s_md  <= dec(vis[4], bin_mode);
        s_mo  <= dec(vis[5], bin_mode);
        s_yr  <= dec(vis[6], bin_mode);
      end else if (tick_run) begin
        {s_sec, s_min, s_hr, s_wd, s_md, s_mo, s_yr} <= {n_sec, n_min, n_hr, n_wd, n_md, n_mo, n_yr};
      end
    end
  end

  assign sec_q = vis[0]; assign min_q = vis[1]; assign hour_q = vis[2];
  assign wday_q = vis[3]; assign mday_q = vis[4]; assign mon_q = vis[5];
  assign year_q = vis[6];

  assert_uip_from_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uip) |-> $past(sec_tick && osc_ctl == 3'b010 && !set_mode));
  assert_flag_after_uip_R7: assert property (@(posedge clk) disable iff (!rst_n)
    upd_flag |-> !uip);
  assert_flag_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    upd_flag |=> !upd_flag);
  assert_alarm_raises_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    alm_flag |-> (irq_flag && upd_flag));
  assert_frozen_view_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(set_mode) && !$past(wr_en)) |-> ($stable(sec_q) && $stable(hour_q) && $stable(mday_q)));
  assert_no_uip_in_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (set_mode && $past(set_mode) && !uip) |=> !uip);
endmodule

// File: tb/test_cal_counter.sv
module test_cal_counter;
  localparam int PERIOD = 10;
  localparam int DLY = 8;

  logic clk = 0, rst_n = 0, sec_tick = 0, set_mode = 0, bin_mode = 0, h24_mode = 1;
  logic upd_ie = 0, alm_ie = 0, wr_en = 0;
  logic [2:0] osc_ctl = 3'b010, wr_sel = 0;
  logic [7:0] alm_sec = 8'hC0, alm_min = 8'hC0, alm_hour = 8'hC0, wr_data = 0;
  logic [7:0] sec_q, min_q, hour_q, wday_q, mday_q, mon_q, year_q;
  logic uip, upd_flag, irq_flag, alm_flag;
  int checks = 0, fails = 0;
  logic u1, ud, uf, fu, fi, fa;

  always #(PERIOD/2) clk = ~clk;

  cal_counter #(.UPDATE_DELAY(DLY), .BASE_YEAR(2000)) i_cal_counter (
    .clk, .rst_n, .sec_tick, .osc_ctl, .set_mode, .bin_mode, .h24_mode, .upd_ie, .alm_ie,
    .alm_sec, .alm_min, .alm_hour, .wr_en, .wr_sel, .wr_data,
    .sec_q, .min_q, .hour_q, .wday_q, .mday_q, .mon_q, .year_q,
    .uip, .upd_flag, .irq_flag, .alm_flag);

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic set_time(input logic [7:0] s, m, h);
    wr(3'd0, s); wr(3'd1, m); wr(3'd2, h);
  endtask

  task automatic do_tick();
    @(negedge clk); sec_tick = 1;
    @(negedge clk); sec_tick = 0; u1 = uip;
    repeat (DLY - 1) @(negedge clk);
    ud = uip;
    @(negedge clk); uf = uip; fu = upd_flag; fi = irq_flag; fa = alm_flag;
  endtask

  task automatic t_reset();
    chk("R1 sec", sec_q, 8'h00); chk("R1 min", min_q, 8'h00); chk("R1 hour", hour_q, 8'h00);
    chk("R1 wday", wday_q, 8'h01); chk("R1 mday", mday_q, 8'h01); chk("R1 mon", mon_q, 8'h01);
    chk("R1 year", year_q, 8'h00);
    chk("R1 flags", {4'b0, uip, upd_flag, irq_flag, alm_flag}, 8'h00);
  endtask

  task automatic t_rollover();
    wr(3'd6, 8'h99); wr(3'd5, 8'h12); wr(3'd4, 8'h31); wr(3'd3, 8'h07);
    set_time(8'h59, 8'h59, 8'h23);
    chk("R11 readback", min_q, 8'h59);
    do_tick();
    chk("R3 sec", sec_q, 8'h00); chk("R3 min", min_q, 8'h00); chk("R3 hour", hour_q, 8'h00);
    chk("R3 wday", wday_q, 8'h01); chk("R3 mday", mday_q, 8'h01); chk("R3 mon", mon_q, 8'h01);
    chk("R3 year", year_q, 8'h00);
  endtask

  task automatic t_sequence();
    wr(3'd0, 8'h41);
    do_tick();
    chk("R7 uip rise", {7'b0, u1}, 8'h01); chk("R7 uip held", {7'b0, ud}, 8'h01);
    chk("R7 uip fall", {7'b0, uf}, 8'h00); chk("R7 upd pulse", {7'b0, fu}, 8'h01);
    chk("R11 continue", sec_q, 8'h42);
    chk("R8 no irq", {7'b0, fi}, 8'h00);
    @(negedge clk); chk("R7 pulse width", {7'b0, upd_flag}, 8'h00);
    upd_ie = 1; do_tick();
    chk("R8 irq", {6'b0, fu, fi}, 8'h03);
    upd_ie = 0;
  endtask

  task automatic t_month(input logic [7:0] y, mo, md, input logic [7:0] emd, emo, input string tag);
    wr(3'd6, y); wr(3'd5, mo); wr(3'd4, md); set_time(8'h59, 8'h59, 8'h23);
    do_tick();
    chk(tag, mday_q, emd); chk(tag, mon_q, emo);
  endtask

  task automatic t_binary();
    bin_mode = 1;
    wr(3'd0, 8'd59); wr(3'd1, 8'd9); wr(3'd2, 8'd17);
    do_tick();
    chk("R5 bin sec", sec_q, 8'd0); chk("R5 bin min", min_q, 8'd10); chk("R5 bin hour", hour_q, 8'd17);
    bin_mode = 0;
    wr(3'd0, 8'h18); do_tick();
    chk("R5 bcd sec", sec_q, 8'h19);
  endtask

  task automatic t_12h();
    h24_mode = 0;
    set_time(8'h59, 8'h59, 8'h11);
    do_tick();
    chk("R6 noon", hour_q, 8'h80);
    set_time(8'h59, 8'h59, 8'h81);
    do_tick();
    chk("R6 pm", hour_q, 8'h82);
    h24_mode = 1;
    do_tick();
    chk("R6 24h view", hour_q, 8'h14);
  endtask

  task automatic t_osc();
    wr(3'd0, 8'h20);
    osc_ctl = 3'b000;
    do_tick();
    chk("R2 no uip", {7'b0, u1}, 8'h00); chk("R2 no flag", {7'b0, fu}, 8'h00);
    chk("R2 held", sec_q, 8'h20);
    osc_ctl = 3'b010;
    do_tick();
    chk("R2 resumes", sec_q, 8'h21);
  endtask

  task automatic t_set();
    @(negedge clk); set_mode = 1;
    do_tick();
    chk("R10 no uip", {7'b0, u1}, 8'h00); chk("R10 upd", {7'b0, fu}, 8'h01);
    chk("R10 frozen", sec_q, 8'h21);
    wr(3'd0, 8'h30);
    chk("R10 write view", sec_q, 8'h30);
    @(negedge clk); set_mode = 0;
    @(negedge clk);
    do_tick();
    chk("R10 reload", sec_q, 8'h31);
  endtask

  task automatic t_alarm();
    alm_ie = 1;
    set_time(8'h04, 8'h20, 8'h10);
    alm_sec = 8'h05; alm_min = 8'hC0; alm_hour = 8'hC0;
    do_tick();
    chk("R9 match", {6'b0, fa, fi}, 8'h03);
    alm_sec = 8'h07; do_tick();
    chk("R9 miss", {6'b0, fa, fi}, 8'h00);
    alm_sec = 8'hC0; alm_min = 8'h20; alm_hour = 8'h10; do_tick();
    chk("R9 hour match", {7'b0, fa}, 8'h01);
    alm_hour = 8'h11; do_tick();
    chk("R9 hour miss", {7'b0, fa}, 8'h00);
    alm_hour = 8'hC0; alm_min = 8'hC0; alm_ie = 0; do_tick();
    chk("R9 disabled", {6'b0, fa, fi}, 8'h00);
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_rollover();
    t_sequence();
    t_month(8'h24, 8'h02, 8'h28, 8'h29, 8'h02, "R4 leap 28");
    t_month(8'h24, 8'h02, 8'h29, 8'h01, 8'h03, "R4 leap 29");
    t_month(8'h23, 8'h02, 8'h28, 8'h01, 8'h03, "R4 common feb");
    t_month(8'h00, 8'h02, 8'h28, 8'h29, 8'h02, "R4 div400");
    t_month(8'h23, 8'h04, 8'h30, 8'h01, 8'h05, "R4 april");
    t_month(8'h23, 8'h01, 8'h30, 8'h31, 8'h01, "R4 january");
    t_binary();
    t_12h();
    t_osc();
    t_set();
    t_alarm();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule